// File: doc/BRIEF.md
# Min/Max/Average Sample Reducer

The reducer sits between a multi-channel acquisition front end and a capture memory. On every enabled clock it takes one sample from each of four signed 10-bit analog channels and one 32-bit digital channel. It keeps four running results side by side: a per-channel minimum, a per-channel maximum, and two words that each hold running sums of a pair of analog channels. The digital lines have no ordering, so the minimum word folds them with AND and the maximum word folds them with OR.

A latch input copies all four running results into a snapshot bank. A 2-bit select input then chooses which snapshot word is presented as the 72-bit memory write word. A pass-through input bypasses the reduction and presents the raw packed sample instead. A restart input seeds every running result from the current sample, which opens a new reduction window. A sample-enable input gates all of this, so the block can run at a decimated rate.

Top module: `sample_reducer`

## Requirements
- R1: The packed word holds analog channel 0 in bits 9:0, channel 1 in 19:10, channel 2 in 29:20, channel 3 in 39:30 and the digital sample in 71:40.
- R2: The minimum word keeps, per analog channel, the smallest sample seen under signed comparison. It is replaced only when a new sample is strictly smaller. Its digital field is the bitwise AND of the digital samples.
- R3: The maximum word keeps, per analog channel, the largest sample seen under signed comparison. It is replaced only when a new sample is strictly larger. Its digital field is the bitwise OR of the digital samples.
- R4: The first sum word holds the running sum of channel 0 in bits 35:0 and of channel 1 in bits 71:36. Each sample is sign-extended to 36 bits before it is added.
- R5: The second sum word holds the sign-extended running sum of channel 2 in bits 35:0 and of channel 3 in bits 71:36.
- R6: With pass-through low, the select input picks the output word combinationally: 0 gives minimum, 1 gives maximum, 2 gives the first sum word and 3 gives the second sum word.
- R7: When a sample is taken with latch high, the snapshot bank loads the running results that include that sample. Without such a sample the snapshot holds.
- R8: A sample presented before clock edge k is reflected on the output after edge k+1 (two-cycle latency).
- R9: An asynchronous active-low reset clears all running results, the snapshot and the pass-through register, so the output reads zero.
- R10: When sample-enable is low, the inputs, restart and latch have no effect on any state.
- R11: A sample taken with restart high loads the minimum and maximum with the sample, loads each sum with the sign-extended sample, and loads both digital fields with the digital sample.
- R12: With pass-through high, the output is the raw packed sample (layout of R1) of the most recent enabled sample, with the same latency as R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_en | input | 1 | Take the current sample this cycle |
| restart | input | 1 | Seed running results from this sample |
| latch | input | 1 | Copy running results (including this sample) to the snapshot |
| pass | input | 1 | Output the raw packed sample instead of a snapshot word |
| mode | input | 2 | Snapshot word select: 0 min, 1 max, 2 sums of ch0/ch1, 3 sums of ch2/ch3 |
| ana_in | input | 40 | Four signed 10-bit samples, channel n at bits 10n+9:10n |
| dig_in | input | 32 | Digital channel sample |
| mem_word | output | 72 | Memory write word |

## Verification
The bench builds the block with its default widths: 10-bit analog samples, a 32-bit digital field and 36-bit sums. With 10-bit samples, runs of uniform -512 or +511 samples drive the signed strict comparisons and the sign extension of the sums to their extremes within a few hundred cycles. Because the bench model recomputes every word on every cycle, a fault in one field shows up as soon as that word is selected. The narrow samples against wide sums mean sum wrap-around is out of reach in any practical run, so the run checks sign handling rather than overflow.

// File: rtl/sr_pkg.sv
package sr_pkg;
    localparam int N_CH = 4;

    typedef enum logic [1:0] {
        SEL_MIN   = 2'd0,
        SEL_MAX   = 2'd1,
        SEL_SUM_A = 2'd2,
        SEL_SUM_B = 2'd3
    } sel_e;
endpackage

// File: rtl/sr_capture.sv
// Input stage: registers one sample and its control flags.
module sr_capture #(
    parameter int ANA_W = 10,
    parameter int DIG_W = 32,
    parameter int N_CH  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_en,
    input  logic                    restart,
    input  logic                    latch,
    input  logic [N_CH*ANA_W-1:0]   ana_in,
    input  logic [DIG_W-1:0]        dig_in,
    output logic                    s_vld,
    output logic                    s_seed,
    output logic                    s_lat,
    output logic [N_CH*ANA_W-1:0]   s_ana,
    output logic [DIG_W-1:0]        s_dig
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_vld  <= 1'b0;
            s_seed <= 1'b0;
            s_lat  <= 1'b0;
            s_ana  <= '0;
            s_dig  <= '0;
        end else begin
            s_vld  <= smp_en;
            s_seed <= restart;
            s_lat  <= latch;
            s_ana  <= ana_in;
            s_dig  <= dig_in;
        end
    end
endmodule

// File: rtl/sr_lane.sv
// One analog channel: signed running minimum and maximum.
module sr_lane #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         vld,
    input  logic         seed,
    input  logic [W-1:0] smp,
    output logic [W-1:0] run_min,
    output logic [W-1:0] run_max,
    output logic [W-1:0] nxt_min,
    output logic [W-1:0] nxt_max
);
    always_comb begin
        if (seed) begin
            nxt_min = smp;
            nxt_max = smp;
        end else begin
            nxt_min = ($signed(smp) < $signed(run_min)) ? smp : run_min;
            nxt_max = ($signed(smp) > $signed(run_max)) ? smp : run_max;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_min <= '0;
            run_max <= '0;
        end else if (vld) begin
            run_min <= nxt_min;
            run_max <= nxt_max;
        end
    end
endmodule

// File: rtl/sr_sum.sv
// One analog channel: sign-extended running sum.
module sr_sum #(
    parameter int W     = 10,
    parameter int SUM_W = 36
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld,
    input  logic             seed,
    input  logic [W-1:0]     smp,
    output logic [SUM_W-1:0] nxt_sum
);
    localparam int EXT_W = SUM_W - W;

    logic [SUM_W-1:0] run_sum;
    logic [SUM_W-1:0] ext;

    assign ext     = {{EXT_W{smp[W-1]}}, smp};
    assign nxt_sum = seed ? ext : run_sum + ext;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            run_sum <= '0;
        else if (vld)
            run_sum <= nxt_sum;
    end
endmodule

// File: rtl/sr_digital.sv
// Digital field: AND-fold for the minimum word, OR-fold for the maximum word.
module sr_digital #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         vld,
    input  logic         seed,
    input  logic [W-1:0] smp,
    output logic [W-1:0] run_and,
    output logic [W-1:0] run_or,
    output logic [W-1:0] nxt_and,
    output logic [W-1:0] nxt_or
);
    assign nxt_and = seed ? smp : (run_and & smp);
    assign nxt_or  = seed ? smp : (run_or | smp);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_and <= '0;
            run_or  <= '0;
        end else if (vld) begin
            run_and <= nxt_and;
            run_or  <= nxt_or;
        end
    end
endmodule

// File: rtl/sample_reducer.sv
module sample_reducer
    import sr_pkg::*;
#(
    parameter int ANA_W = 10,
    parameter int DIG_W = 32
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                smp_en,
    input  logic                                restart,
    input  logic                                latch,
    input  logic                                pass,
    input  logic [1:0]                          mode,
    input  logic [N_CH*ANA_W-1:0]               ana_in,
    input  logic [DIG_W-1:0]                    dig_in,
    output logic [N_CH*ANA_W+DIG_W-1:0]         mem_word
);
    localparam int PACK_W = N_CH * ANA_W;
    localparam int WORD_W = PACK_W + DIG_W;
    localparam int SUM_W  = WORD_W / 2;

    logic              s_vld, s_seed, s_lat;
    logic [PACK_W-1:0] s_ana;
    logic [DIG_W-1:0]  s_dig;

    logic [PACK_W-1:0] run_min_w, run_max_w, nxt_min_w, nxt_max_w;
    logic [SUM_W-1:0]  nxt_sum [N_CH];
    logic [DIG_W-1:0]  run_and, run_or, nxt_and, nxt_or;

    logic [WORD_W-1:0] nxt_word [N_CH];
    logic [WORD_W-1:0] snap     [N_CH];
    logic [WORD_W-1:0] raw_q;
    sel_e              sel;

    sr_capture #(.ANA_W(ANA_W), .DIG_W(DIG_W), .N_CH(N_CH)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .smp_en (smp_en),
        .restart(restart),
        .latch  (latch),
        .ana_in (ana_in),
        .dig_in (dig_in),
        .s_vld  (s_vld),
        .s_seed (s_seed),
        .s_lat  (s_lat),
        .s_ana  (s_ana),
        .s_dig  (s_dig)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        sr_lane #(.W(ANA_W)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .vld    (s_vld),
            .seed   (s_seed),
            .smp    (s_ana[c*ANA_W +: ANA_W]),
            .run_min(run_min_w[c*ANA_W +: ANA_W]),
            .run_max(run_max_w[c*ANA_W +: ANA_W]),
            .nxt_min(nxt_min_w[c*ANA_W +: ANA_W]),
            .nxt_max(nxt_max_w[c*ANA_W +: ANA_W])
        );

        sr_sum #(.W(ANA_W), .SUM_W(SUM_W)) u_sum (
            .clk    (clk),
            .rst_n  (rst_n),
            .vld    (s_vld),
            .seed   (s_seed),
            .smp    (s_ana[c*ANA_W +: ANA_W]),
            .nxt_sum(nxt_sum[c])
        );
    end

    sr_digital #(.W(DIG_W)) u_dig (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld    (s_vld),
        .seed   (s_seed),
        .smp    (s_dig),
        .run_and(run_and),
        .run_or (run_or),
        .nxt_and(nxt_and),
        .nxt_or (nxt_or)
    );

    // Next-state result words in select-index order
    always_comb begin
        nxt_word[SEL_MIN]   = {nxt_and, nxt_min_w};
        nxt_word[SEL_MAX]   = {nxt_or,  nxt_max_w};
        nxt_word[SEL_SUM_A] = {nxt_sum[1], nxt_sum[0]};
        nxt_word[SEL_SUM_B] = {nxt_sum[3], nxt_sum[2]};
    end

    // Snapshot bank and raw pass-through register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_CH; i++) snap[i] <= '0;
            raw_q <= '0;
        end else if (s_vld) begin
            raw_q <= {s_dig, s_ana};
            if (s_lat)
                for (int i = 0; i < N_CH; i++) snap[i] <= nxt_word[i];
        end
    end

    assign sel = sel_e'(mode);

    always_comb begin
        if (pass) begin
            mem_word = raw_q;
        end else begin
            unique case (sel)
                SEL_MIN:   mem_word = snap[0];
                SEL_MAX:   mem_word = snap[1];
                SEL_SUM_A: mem_word = snap[2];
                SEL_SUM_B: mem_word = snap[3];
                default:   mem_word = snap[0];
            endcase
        end
    end
endmodule

// File: rtl/sample_reducer_chk.sv
module sample_reducer_chk #(
    parameter int ANA_W = 10,
    parameter int DIG_W = 32,
    parameter int N_CH  = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        smp_en,
    input logic                        latch,
    input logic                        pass,
    input logic [1:0]                  mode,
    input logic [N_CH*ANA_W-1:0]       ana_in,
    input logic [DIG_W-1:0]            dig_in,
    input logic [N_CH*ANA_W+DIG_W-1:0] mem_word,
    input logic [N_CH*ANA_W-1:0]       run_min_w,
    input logic [N_CH*ANA_W-1:0]       run_max_w,
    input logic [DIG_W-1:0]            run_and,
    input logic [DIG_W-1:0]            run_or
);
    // R9
    always @(posedge clk)
        if (!rst_n) reset_clear_chk: assert (mem_word == '0);

    // R12
    pass_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pass && $past(smp_en, 2)) |-> (mem_word == {$past(dig_in, 2), $past(ana_in, 2)}));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pass && $past(pass) && !$past(smp_en, 2)) |-> $stable(mem_word));

    // R7
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pass && !$past(pass) && (mode == $past(mode)) &&
         !($past(latch, 2) && $past(smp_en, 2))) |-> $stable(mem_word));

    // R3
    dig_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((run_and & ~run_or) == '0));

    for (genvar c = 0; c < N_CH; c++) begin : g_ord
        // R2
        min_le_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $signed(run_min_w[c*ANA_W +: ANA_W]) <= $signed(run_max_w[c*ANA_W +: ANA_W]));
    end
endmodule

bind sample_reducer sample_reducer_chk #(.ANA_W(ANA_W), .DIG_W(DIG_W), .N_CH(sr_pkg::N_CH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_en   (smp_en),
    .latch    (latch),
    .pass     (pass),
    .mode     (mode),
    .ana_in   (ana_in),
    .dig_in   (dig_in),
    .mem_word (mem_word),
    .run_min_w(run_min_w),
    .run_max_w(run_max_w),
    .run_and  (run_and),
    .run_or   (run_or)
);

// File: tb/tb_sample_reducer.sv
`timescale 1ns/1ps
module tb_sample_reducer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic        smp_en = 1'b0, restart = 1'b0, latch = 1'b0, pass = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [39:0] ana_in = '0;
    logic [31:0] dig_in = '0;
    logic [71:0] mem_word;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;   // 50 MHz

    sample_reducer dut (
        .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .restart(restart),
        .latch(latch), .pass(pass), .mode(mode), .ana_in(ana_in),
        .dig_in(dig_in), .mem_word(mem_word)
    );

    // Behavioural reference model
    logic              p_vld, p_rst, p_lat;
    logic [39:0]       p_ana;
    logic [31:0]       p_dig;
    logic signed [9:0] m_min [4];
    logic signed [9:0] m_max [4];
    logic [35:0]       m_sum [4];
    logic [31:0]       m_and, m_or;
    logic [71:0]       m_snap [4];
    logic [71:0]       m_raw;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_vld = 0; p_rst = 0; p_lat = 0; p_ana = '0; p_dig = '0;
            m_and = '0; m_or = '0; m_raw = '0;
            for (int i = 0; i < 4; i++) begin
                m_min[i] = '0; m_max[i] = '0; m_sum[i] = '0; m_snap[i] = '0;
            end
        end else begin
            if (p_vld) begin
                for (int i = 0; i < 4; i++) begin
                    int x;
                    x = $signed(p_ana[i*10 +: 10]);
                    if (p_rst) begin
                        m_min[i] = 10'(x); m_max[i] = 10'(x); m_sum[i] = 36'(x);
                    end else begin
                        if (x < int'(m_min[i])) m_min[i] = 10'(x);
                        if (x > int'(m_max[i])) m_max[i] = 10'(x);
                        m_sum[i] = m_sum[i] + 36'(x);
                    end
                end
                m_and = p_rst ? p_dig : (m_and & p_dig);
                m_or  = p_rst ? p_dig : (m_or | p_dig);
                m_raw = {p_dig, p_ana};
                if (p_lat) begin
                    m_snap[0] = {m_and, m_min[3], m_min[2], m_min[1], m_min[0]};
                    m_snap[1] = {m_or,  m_max[3], m_max[2], m_max[1], m_max[0]};
                    m_snap[2] = {m_sum[1], m_sum[0]};
                    m_snap[3] = {m_sum[3], m_sum[2]};
                end
            end
            p_vld = smp_en; p_rst = restart; p_lat = latch;
            p_ana = ana_in; p_dig = dig_in;
        end
    end

    function automatic string mtag();
        if (pass) return "R12 pass";
        case (mode)
            2'd0: return "R2 min";
            2'd1: return "R3 max";
            2'd2: return "R4 sumA";
            default: return "R5 sumB";
        endcase
    endfunction

    task automatic expect_word(string tag, logic [71:0] exp);
        checks++;
        if (mem_word !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, mem_word, exp);
        end
    endtask

    task automatic tick(string ph);
        @(negedge clk);
        expect_word({ph, " ", mtag()}, pass ? m_raw : m_snap[mode]);
    endtask

    task automatic run(string ph, int n, int en_pct, int lat_pct, int rst_pct,
                       int pass_sel, int mode_sel, bit extreme);
        for (int k = 0; k < n; k++) begin
            tick(ph);
            smp_en  = ($urandom % 100) < en_pct;
            latch   = ($urandom % 100) < lat_pct;
            restart = ($urandom % 100) < rst_pct;
            pass    = (pass_sel < 0) ? 1'($urandom % 2) : 1'(pass_sel);
            mode    = (mode_sel < 0) ? 2'($urandom % 4) : 2'(mode_sel);
            for (int c = 0; c < 4; c++)
                ana_in[c*10 +: 10] = extreme ? (($urandom % 2) ? 10'h1FF : 10'h200)
                                             : 10'($urandom);
            dig_in = $urandom;
        end
    endtask

    initial begin
        #(200000 * 20);
        fails++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [39:0] a;
        #5 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: output zero in reset, in every select
        for (int m = 0; m < 5; m++) begin
            pass = (m == 4); mode = 2'(m);
            #1 expect_word("R9 reset", '0);
        end
        rst_n = 1'b1;
        pass = 1'b0; mode = 2'd0;
        run("R9", 3, 0, 0, 0, -1, -1, 0);

        // R8/R1: directed latency and packing
        @(negedge clk);
        pass = 1'b1;
        a = {10'h200, 10'd100, 10'h3FD, 10'd5};
        ana_in = a; dig_in = 32'hA5C3_0F11; smp_en = 1'b1;
        @(negedge clk);
        smp_en = 1'b0;
        expect_word("R8 one edge", '0);
        @(negedge clk);
        expect_word("R8 two edges", {32'hA5C3_0F11, a});
        checks++;
        if (mem_word[29:20] !== 10'd100 || mem_word[71:40] !== 32'hA5C3_0F11) begin
            fails++;
            $display("FAIL R1 packing: got %h expected ch2=064 dig=a5c30f11", mem_word);
        end

        // R2..R5: continuous reduction without restart (from zero after reset)
        for (int m = 0; m < 4; m++) run("R6", 40, 100, 100, 0, 0, m, 0);
        run("R6", 80, 100, 100, 0, 0, -1, 0);
        // R11: restart seeding, then windows
        run("R11", 150, 100, 100, 15, 0, -1, 0);
        // R7: sparse latch
        run("R7", 200, 100, 20, 5, 0, -1, 0);
        // R10: sparse sample enable
        run("R10", 200, 30, 60, 10, -1, -1, 0);
        // R12: pass-through
        run("R12", 120, 70, 50, 10, 1, 0, 0);
        // R4/R5 sign extension and strict compares at extremes
        run("R4", 300, 100, 100, 2, 0, -1, 1);
        // R9: reset in mid-run
        @(negedge clk);
        smp_en = 1'b0; latch = 1'b0; restart = 1'b0;
        rst_n = 1'b0;
        #1 expect_word("R9 mid-run", '0);
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        run("R9", 100, 80, 50, 0, -1, -1, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule